// File: doc/BRIEF.md
# Seven-to-One Pixel Serializer for a Flat-Panel Link

This block turns one 18-bit RGB pixel (six bits each of red, green and blue) plus horizontal sync, vertical sync and data-enable into three serial data lanes and one forwarded clock lane. It runs on the bit clock, which is seven times the pixel rate. A slot counter splits the bit clock into seven-slot pixel periods. On slot 0 of each period the pixel on the inputs is captured, packed into three 7-bit words and shifted out most significant slot first. A fixed 7-bit clock pattern goes out at the same time. The four single-ended outputs stand for the differential pairs that an analog driver outside the block would produce.

A crossbar after the shifters lets software place any source lane on any output. Each output can also be inverted on its own. Both settings are sampled on every bit cycle. The upstream pixel source uses `pix_strobe` to learn when its next pixel is taken. When `en` is low, all four outputs drive a constant low level and the slot counter rewinds.

Top module: `lvds_pixel_serializer`

## Requirements
- R1: After synchronous reset, `lane_out` is all zeros and `pix_strobe` is 1.
- R2: While `en` is high, `pix_strobe` is high for exactly one cycle in seven. The pixel inputs are captured at the rising edge that ends a cycle in which both `pix_strobe` and `en` are high.
- R3: Data source 0 carries, from slot 0 to slot 6: green bit 0, then red bits 5, 4, 3, 2, 1, 0.
- R4: Data source 1 carries, from slot 0 to slot 6: blue bit 1, blue bit 0, then green bits 5, 4, 3, 2, 1.
- R5: Data source 2 carries, from slot 0 to slot 6: data-enable, vertical sync, horizontal sync, then blue bits 5, 4, 3, 2.
- R6: Source 3 is the forwarded clock. It carries the pattern 1,1,0,0,0,1,1 over slots 0 to 6 of every pixel period, aligned with slot 0 of the data sources.
- R7: Slot k of a pixel captured at edge E is visible on `lane_out` after edge E+1+k. Consecutive pixels follow with no gap.
- R8: Output k carries the source selected by `lane_sel[2k+1:2k]`, using the codes 0, 1, 2 for the data sources and 3 for the clock. Several outputs may select the same source.
- R9: When `lane_inv[k]` is 1, output k carries the complement of its selected source bit.
- R10: One cycle after `en` is sampled low, all outputs are 0 whatever `lane_inv` holds, and `pix_strobe` is 1. The first edge at which `en` is high again captures a pixel.
- R11: A change to `lane_sel` or `lane_inv` takes effect on the next output bit, so the routing can be changed between pixels while the link runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Serializer enable; when low, all outputs are held low |
| pix_red | input | 6 | Red component of the pixel |
| pix_green | input | 6 | Green component of the pixel |
| pix_blue | input | 6 | Blue component of the pixel |
| pix_hsync | input | 1 | Horizontal sync of the pixel |
| pix_vsync | input | 1 | Vertical sync of the pixel |
| pix_de | input | 1 | Data-enable of the pixel |
| lane_sel | input | 8 | Source select, 2 bits per output lane |
| lane_inv | input | 4 | Per-output polarity invert |
| pix_strobe | output | 1 | High in the cycle whose closing edge captures a pixel |
| lane_out | output | 4 | Serial output bits, one per lane |

## Verification
The assertions check the timing skeleton on every cycle:
- the slot counter stays in range and wraps;
- the strobe lines up with slot 0;
- a capture loads the packed word;
- a disable clears the outputs and rewinds the counter on the next edge.

The bit order inside each lane, the clock pattern, the latency from capture to slot 0, the crossbar routing and the inversion can only be shown by the bench's scenarios. These deserialize every output lane and compare it with words built from the input pixels. The scenarios also cover routing changed between pixels, several outputs on one source, and a restart after a disable in the middle of a pixel.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;
  localparam int COLOR_W    = 6;
  localparam int NUM_DATA   = 3;
  localparam int NUM_SRC    = NUM_DATA + 1;
  localparam int LANE_SLOTS = 7;
  localparam int SRC_SEL_W  = $clog2(NUM_SRC);

  typedef enum logic [SRC_SEL_W-1:0] {
    SRC_RED_LO = 2'd0,
    SRC_GRN_BL = 2'd1,
    SRC_SYNC   = 2'd2,
    SRC_CLOCK  = 2'd3
  } src_code_e;

  typedef struct packed {
    logic               de;
    logic               vsync;
    logic               hsync;
    logic [COLOR_W-1:0] red;
    logic [COLOR_W-1:0] green;
    logic [COLOR_W-1:0] blue;
  } pixel_t;
endpackage

// File: rtl/ser_slot_ctr.sv
module ser_slot_ctr #(
  parameter int SLOTS = 7,
  localparam int CNT_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic             load,
  output logic             strobe_q,
  output logic [CNT_W-1:0] slot_q
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS - 1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      slot_q   <= '0;
      strobe_q <= 1'b1;
    end else begin
      slot_q   <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
      strobe_q <= (slot_q == LAST);
    end
  end

  assign load = en && (slot_q == '0);

  // R2
  slot_range_chk: assert property (@(posedge clk) disable iff (rst)
    slot_q <= LAST);

  // R2
  strobe_align_chk: assert property (@(posedge clk) disable iff (rst)
    (en && strobe_q) |-> (slot_q == '0));

  // R2
  slot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (en && slot_q == LAST) |=> strobe_q);

  // R10
  idle_rewind_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (slot_q == '0 && strobe_q));
endmodule

// File: rtl/ser_pixel_pack.sv
module ser_pixel_pack
  import lvds_ser_pkg::*;
#(
  parameter int              SLOTS       = LANE_SLOTS,
  parameter logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011
) (
  input  pixel_t                        pix,
  output logic [NUM_SRC-1:0][SLOTS-1:0] words
);
  // Most significant bit of each word is slot 0.
  always_comb begin
    words[SRC_RED_LO] = {pix.green[0], pix.red};
    words[SRC_GRN_BL] = {pix.blue[1:0], pix.green[COLOR_W-1:1]};
    words[SRC_SYNC]   = {pix.de, pix.vsync, pix.hsync, pix.blue[COLOR_W-1:2]};
    words[SRC_CLOCK]  = CLK_PATTERN;
  end
endmodule

// File: rtl/ser_lane_shift.sv
module ser_lane_shift #(
  parameter int SLOTS = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  logic [SLOTS-1:0] din,
  output logic             bit_out
);
  logic [SLOTS-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst || !en)
      word_q <= '0;
    else if (load)
      word_q <= din;
    else
      word_q <= {word_q[SLOTS-2:0], 1'b0};
  end

  assign bit_out = word_q[SLOTS-1];

  // R7
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (word_q == $past(din)));
endmodule

// File: rtl/ser_lane_xbar.sv
module ser_lane_xbar
  import lvds_ser_pkg::*;
#(
  parameter int LANES = NUM_SRC,
  localparam int SEL_W = SRC_SEL_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic [NUM_SRC-1:0]     src_bits,
  input  logic [LANES*SEL_W-1:0] sel,
  input  logic [LANES-1:0]       inv,
  output logic [LANES-1:0]       lane_q
);
  for (genvar k = 0; k < LANES; k++) begin : g_out
    logic [SEL_W-1:0] pick;
    assign pick = sel[k*SEL_W +: SEL_W];

    always_ff @(posedge clk) begin
      if (rst || !en)
        lane_q[k] <= 1'b0;
      else
        lane_q[k] <= src_bits[pick] ^ inv[k];
    end
  end
endmodule

// File: rtl/lvds_pixel_serializer.sv
module lvds_pixel_serializer
  import lvds_ser_pkg::*;
#(
  parameter int               SLOTS       = LANE_SLOTS,
  parameter int               LANES       = NUM_SRC,
  parameter logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011,
  localparam int SEL_W = SRC_SEL_W,
  localparam int CNT_W = $clog2(SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic [COLOR_W-1:0]     pix_red,
  input  logic [COLOR_W-1:0]     pix_green,
  input  logic [COLOR_W-1:0]     pix_blue,
  input  logic                   pix_hsync,
  input  logic                   pix_vsync,
  input  logic                   pix_de,
  input  logic [LANES*SEL_W-1:0] lane_sel,
  input  logic [LANES-1:0]       lane_inv,
  output logic                   pix_strobe,
  output logic [LANES-1:0]       lane_out
);
  pixel_t                        pix;
  logic                          load;
  logic [CNT_W-1:0]              slot;
  logic [NUM_SRC-1:0][SLOTS-1:0] words;
  logic [NUM_SRC-1:0]            src_bits;

  assign pix = '{de: pix_de, vsync: pix_vsync, hsync: pix_hsync,
                 red: pix_red, green: pix_green, blue: pix_blue};

  ser_slot_ctr #(.SLOTS(SLOTS)) u_ctr (
    .clk(clk), .rst(rst), .en(en),
    .load(load), .strobe_q(pix_strobe), .slot_q(slot)
  );

  ser_pixel_pack #(.SLOTS(SLOTS), .CLK_PATTERN(CLK_PATTERN)) u_pack (
    .pix(pix), .words(words)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    ser_lane_shift #(.SLOTS(SLOTS)) u_shift (
      .clk(clk), .rst(rst), .en(en), .load(load),
      .din(words[s]), .bit_out(src_bits[s])
    );
  end

  ser_lane_xbar #(.LANES(LANES)) u_xbar (
    .clk(clk), .rst(rst), .en(en),
    .src_bits(src_bits), .sel(lane_sel), .inv(lane_inv),
    .lane_q(lane_out)
  );

  // R10
  disable_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (lane_out == '0));

  // R2
  capture_slot_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (slot == CNT_W'(1) || SLOTS == 1));
endmodule

// File: tb/test_lvds_pixel_serializer.sv
`timescale 1ns/1ps
module test_lvds_pixel_serializer;
  typedef struct packed {
    logic       de;
    logic       vsync;
    logic       hsync;
    logic [5:0] red;
    logic [5:0] green;
    logic [5:0] blue;
  } bpix_t;

  logic       clk = 1'b0;
  logic       rst, en;
  logic [5:0] pix_red, pix_green, pix_blue;
  logic       pix_hsync, pix_vsync, pix_de;
  logic [7:0] lane_sel;
  logic [3:0] lane_inv;
  logic       pix_strobe;
  logic [3:0] lane_out;

  always #2.5 clk = ~clk;

  lvds_pixel_serializer i_lvds_pixel_serializer (
    .clk(clk), .rst(rst), .en(en),
    .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue),
    .pix_hsync(pix_hsync), .pix_vsync(pix_vsync), .pix_de(pix_de),
    .lane_sel(lane_sel), .lane_inv(lane_inv),
    .pix_strobe(pix_strobe), .lane_out(lane_out)
  );

  int checks = 0, errors = 0, nc = 0;

  bit         pend_v = 0, act_v = 0;
  int         pend_t, act_t;
  bpix_t      pend_p, act_p;
  logic [7:0] pend_sel, act_sel;
  logic [3:0] pend_inv, act_inv;
  string      pend_tag, act_tag;
  logic [6:0] w [4];

  localparam logic [7:0] IDENT = 8'b11_10_01_00;

  function automatic logic [6:0] src_word(bpix_t p, int s);
    case (s)
      0:       return {p.green[0], p.red};                // R3
      1:       return {p.blue[1:0], p.green[5:1]};        // R4
      2:       return {p.de, p.vsync, p.hsync, p.blue[5:2]}; // R5
      default: return 7'b1100011;                          // R6
    endcase
  endfunction

  function automatic string src_tag(int s);
    case (s)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    nc++;
    if (pend_v && nc - pend_t == 2) begin
      act_p = pend_p; act_sel = pend_sel; act_inv = pend_inv;
      act_tag = pend_tag; act_t = pend_t; act_v = 1; pend_v = 0;
      for (int l = 0; l < 4; l++) w[l] = '0;
    end
    if (act_v) begin
      int s;
      s = nc - act_t - 2;
      for (int l = 0; l < 4; l++) w[l] = {w[l][5:0], lane_out[l]};
      if (s == 6) begin
        for (int l = 0; l < 4; l++) begin
          int src;
          logic [6:0] e;
          src = int'(act_sel[2*l +: 2]);
          e = src_word(act_p, src) ^ {7{act_inv[l]}};
          chk(w[l] == e, {src_tag(src), " R7 ", act_tag, $sformatf(" lane%0d", l)},
              32'(w[l]), 32'(e));
        end
        act_v = 0;
      end
    end
  endtask

  // Called at a negedge where pix_strobe is expected high.
  task automatic send(bpix_t p, logic [7:0] sel, logic [3:0] inv, string tag);
    int cnt;
    chk(pix_strobe === 1'b1, "R2 strobe at drive", 32'(pix_strobe), 32'd1);
    {pix_de, pix_vsync, pix_hsync, pix_red, pix_green, pix_blue} = p;
    pend_p = p; pend_sel = sel; pend_inv = inv; pend_tag = tag;
    pend_t = nc; pend_v = 1;
    tick();
    lane_sel = sel;   // R11: applied before slot 0 of this pixel
    lane_inv = inv;
    cnt = 1;
    while (!pix_strobe && cnt < 20) begin
      tick();
      cnt++;
    end
    chk(cnt == 7, "R2 strobe period", 32'(cnt), 32'd7);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bpix_t p;
    void'($urandom(32'd20240611));
    rst = 1; en = 0;
    {pix_de, pix_vsync, pix_hsync, pix_red, pix_green, pix_blue} = '0;
    lane_sel = IDENT; lane_inv = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    tick();
    // R1
    chk(lane_out == 4'h0, "R1 lanes after reset", 32'(lane_out), 32'h0);
    chk(pix_strobe == 1'b1, "R1 strobe after reset", 32'(pix_strobe), 32'd1);

    // Identity routing, directed and random pixels (R3 R4 R5 R6 R7)
    en = 1;
    send('0, IDENT, 4'h0, "zero");
    send('1, IDENT, 4'h0, "ones");
    p = '0; p.de = 1; send(p, IDENT, 4'h0, "de_only");
    p = '0; p.vsync = 1; p.blue = 6'h2A; send(p, IDENT, 4'h0, "vs_blue");
    for (int i = 0; i < 20; i++) begin
      p = bpix_t'($urandom);
      send(p, IDENT, 4'h0, "random");
    end

    // Routing and polarity changed between pixels (R8 R9 R11)
    for (int i = 0; i < 30; i++) begin
      p = bpix_t'($urandom);
      send(p, 8'($urandom), 4'($urandom), "R8 R9 R11");
    end

    // Every output on the clock source, mixed inversion (R8 R6)
    for (int i = 0; i < 3; i++) begin
      p = bpix_t'($urandom);
      send(p, 8'hFF, 4'b0101, "R8 all_clock");
    end

    // Disable in the middle of a pixel (R10)
    tick(); tick();
    en = 0; lane_inv = 4'hF; pend_v = 0; act_v = 0;
    {pix_de, pix_vsync, pix_hsync, pix_red, pix_green, pix_blue} = 21'($urandom);
    for (int i = 0; i < 5; i++) begin
      tick();
      chk(lane_out == 4'h0, "R10 lanes low while disabled", 32'(lane_out), 32'h0);
      chk(pix_strobe == 1'b1, "R10 strobe while disabled", 32'(pix_strobe), 32'd1);
    end

    // Restart: first enabled edge captures (R10)
    en = 1;
    for (int i = 0; i < 6; i++) begin
      p = bpix_t'($urandom);
      send(p, IDENT, 4'h0, "R10 restart");
    end
    tick(); tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule